// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Stacked Requests

This block decides when a DRAM controller spends bus time on refresh. A programmable interval timer produces refresh demands. While the memory bus is taken by other traffic the demands pile up in a small saturating counter. When the bus is handed over, the block runs CAS-before-RAS refresh cycles back to back and drives the two active-low strobes in the proper order, with the length of each phase set in clock cycles.

The block talks to the rest of the controller through a request/grant pair and an urgent-access input. The urgent input lets a waiting access cut a refresh burst short after the cycle in progress. Refresh can be switched off, and a cycle already under way always runs to its end. A separate external reset input leaves the timer, the pending counter and the sequencer alone, so refresh continues while the system sits in reset. Only the power-on reset clears that state. The external reset clears nothing but the sticky overflow flag.

Top module: `rfsh_sched`

## Requirements
- R1: While `por` is high, and on the first sample after it, `cas_n` and `ras_n` are 1, `bus_req` is 0, `pend_cnt` is 0 and `ovf_flag` is 0.
- R2: With `rfsh_en` high, a refresh demand is generated every `period`+1 clock cycles. Counting clock edges from the first edge after enabling, `pend_cnt` reaches n at edge n·(`period`+1) when nothing is serviced.
- R3: `pend_cnt` saturates at 7. A demand that arrives while the count is 7 and no cycle starts in the same clock is dropped and sets `ovf_flag`, which stays set.
- R4: `bus_req` is raised when `pend_cnt` is non-zero and `rfsh_en` is high, and it stays high until the refresh burst ends.
- R5: In every refresh cycle `cas_n` goes low first. `ras_n` goes low max(`t_cas_ras`,1) cycles later. `ras_n` is never low while `cas_n` is high.
- R6: `ras_n` stays low for max(`t_ras`,1) cycles, then both strobes rise on the same edge. Between chained cycles both strobes stay high for max(`t_pre`,1) cycles.
- R7: While `bus_gnt` is high and `urgent` is low, cycles are chained until `pend_cnt` is 0. Each cycle lowers the count by one. `bus_req` then falls.
- R8: Every grant yields at least one refresh cycle. If `urgent` is high when a precharge ends, the burst stops and `bus_req` drops for at least one cycle.
- R9: With `rfsh_en` low, no demands are generated, no new cycle starts and `pend_cnt` is kept. A cycle in progress completes with full phase lengths, then `bus_req` falls.
- R10: `ext_rst` has no effect on the timer, on `pend_cnt` or on the strobe sequencing.
- R11: `ext_rst` high at a clock edge clears `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| ext_rst | input | 1 | External system reset; clears only the overflow flag |
| rfsh_en | input | 1 | Refresh enable |
| period | input | PER_W | Refresh interval minus one, in cycles |
| t_cas_ras | input | 4 | CAS-to-RAS delay in cycles (0 acts as 1) |
| t_ras | input | 4 | RAS active width in cycles (0 acts as 1) |
| t_pre | input | 4 | Precharge time before a chained cycle (0 acts as 1) |
| urgent | input | 1 | A normal access is waiting; end the burst early |
| bus_gnt | input | 1 | Memory bus granted to refresh |
| bus_req | output | 1 | Refresh requests the memory bus |
| cas_n | output | 1 | Column strobe, active low |
| ras_n | output | 1 | Row strobe, active low |
| pend_cnt | output | CNT_W | Number of stacked refresh demands |
| ovf_flag | output | 1 | Sticky: a demand was dropped because the stack was full |

## Verification
The pending count is due one edge after the timer's terminal cycle, so it reads n exactly at edge n·(period+1) after enabling. The bench samples at the falling edge one cycle before and on that edge, so a timer that is off by one cycle shows up. Strobes are registered from the next state, so each phase length is counted in falling-edge samples between the strobe transitions and compared with max(t,1). Burst-level results (number of RAS pulses, final count, `bus_req` release) are read only after `bus_req` has been seen low, and flag effects of `ext_rst` are read one edge after the pulse.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    localparam int PH_W = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_CAS,
        S_RAS,
        S_PRE
    } seq_st_t;

    typedef struct packed {
        logic [PH_W-1:0] cas_ras;
        logic [PH_W-1:0] ras_act;
        logic [PH_W-1:0] pre;
    } phase_cfg_t;

    // Down-counter preload for a phase of t cycles; zero is treated as one.
    function automatic logic [PH_W-1:0] ph_load(input logic [PH_W-1:0] t);
        return (t == '0) ? '0 : t - 1'b1;
    endfunction

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             por,
    input  logic             en,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    logic [PER_W-1:0] cnt;

    assign tick = en && (cnt >= period);

    always_ff @(posedge clk) begin
        if (por)       cnt <= '0;
        else if (!en)  cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             por,
    input  logic             ext_rst,
    input  logic             tick,
    input  logic             take,
    output logic [CNT_W-1:0] pend,
    output logic             pend_nz,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] MAX_PEND = {CNT_W{1'b1}};

    logic full, accept, drop;

    assign full    = (pend == MAX_PEND);
    assign accept  = tick && (!full || take);
    assign drop    = tick && full && !take;
    assign pend_nz = (pend != '0);

    always_ff @(posedge clk) begin
        if (por) begin
            pend <= '0;
        end else begin
            case ({accept, take})
                2'b10:   pend <= pend + 1'b1;
                2'b01:   pend <= pend - 1'b1;
                default: pend <= pend;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (por)          ovf <= 1'b0;
        else if (ext_rst) ovf <= 1'b0;
        else if (drop)    ovf <= 1'b1;
    end

    // R3: a demand arriving at a full stack is dropped and flagged
    a_r3_saturate: assert property (@(posedge clk) disable iff (por)
        (full && tick && !take && !ext_rst) |=> (pend == MAX_PEND && ovf));

    // R7: a cycle is only ever started against a non-empty stack
    a_r7_take_nonzero: assert property (@(posedge clk) disable iff (por)
        take |-> pend_nz);

    // R10: without timer or service events the count holds, ext_rst or not
    a_r10_count_holds: assert property (@(posedge clk) disable iff (por)
        (!tick && !take) |=> (pend == $past(pend)));

    // R11: external reset clears the overflow flag
    a_r11_ext_clears: assert property (@(posedge clk) disable iff (por)
        ext_rst |=> !ovf);
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
    import rfsh_pkg::*;
(
    input  logic       clk,
    input  logic       por,
    input  logic       en,
    input  logic       urgent,
    input  logic       gnt,
    input  logic       pend_nz,
    input  phase_cfg_t cfg,
    output logic       take,
    output logic       bus_req,
    output logic       cas_n,
    output logic       ras_n
);
    seq_st_t         st, st_nxt;
    logic [PH_W-1:0] ph, ph_nxt;
    logic            chain_ok;

    assign chain_ok = en && gnt && !urgent && pend_nz;

    always_comb begin
        st_nxt = st;
        ph_nxt = ph;
        take   = 1'b0;
        case (st)
            S_IDLE: begin
                if (en && pend_nz) st_nxt = S_REQ;
            end
            S_REQ: begin
                if (!en) begin
                    st_nxt = S_IDLE;
                end else if (gnt) begin
                    st_nxt = S_CAS;
                    ph_nxt = ph_load(cfg.cas_ras);
                    take   = 1'b1;
                end
            end
            S_CAS: begin
                if (ph == '0) begin
                    st_nxt = S_RAS;
                    ph_nxt = ph_load(cfg.ras_act);
                end else begin
                    ph_nxt = ph - 1'b1;
                end
            end
            S_RAS: begin
                if (ph == '0) begin
                    st_nxt = S_PRE;
                    ph_nxt = ph_load(cfg.pre);
                end else begin
                    ph_nxt = ph - 1'b1;
                end
            end
            S_PRE: begin
                if (ph != '0) begin
                    ph_nxt = ph - 1'b1;
                end else if (chain_ok) begin
                    st_nxt = S_CAS;
                    ph_nxt = ph_load(cfg.cas_ras);
                    take   = 1'b1;
                end else begin
                    st_nxt = S_IDLE;
                end
            end
            default: st_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por) begin
            st    <= S_IDLE;
            ph    <= '0;
            cas_n <= 1'b1;
            ras_n <= 1'b1;
        end else begin
            st    <= st_nxt;
            ph    <= ph_nxt;
            cas_n <= !(st_nxt == S_CAS || st_nxt == S_RAS);
            ras_n <= (st_nxt != S_RAS);
        end
    end

    assign bus_req = (st != S_IDLE);

    // R5: the row strobe only falls after the column strobe has been low
    a_r5_cas_first: assert property (@(posedge clk) disable iff (por)
        $fell(ras_n) |-> $past(!cas_n));

    // R6: both strobes are released on the same edge
    a_r6_release_together: assert property (@(posedge clk) disable iff (por)
        $rose(ras_n) |-> $rose(cas_n));

    // R4: a non-empty stack with refresh enabled raises the request
    a_r4_request: assert property (@(posedge clk) disable iff (por)
        (st == S_IDLE && en && pend_nz) |=> bus_req);

    // R8: urgent at the end of precharge starts no further cycle
    a_r8_urgent_stops: assert property (@(posedge clk) disable iff (por)
        (st == S_PRE && ph == '0 && urgent) |=> (cas_n && !bus_req));

    // R9: no cycle begins while refresh is disabled
    a_r9_no_start_disabled: assert property (@(posedge clk) disable iff (por)
        $fell(cas_n) |-> $past(en));
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int PER_W = 16,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             por,
    input  logic             ext_rst,
    input  logic             rfsh_en,
    input  logic [PER_W-1:0] period,
    input  logic [PH_W-1:0]  t_cas_ras,
    input  logic [PH_W-1:0]  t_ras,
    input  logic [PH_W-1:0]  t_pre,
    input  logic             urgent,
    input  logic             bus_gnt,
    output logic             bus_req,
    output logic             cas_n,
    output logic             ras_n,
    output logic [CNT_W-1:0] pend_cnt,
    output logic             ovf_flag
);
    logic       tick, take, pend_nz;
    phase_cfg_t cfg;

    assign cfg = '{cas_ras: t_cas_ras, ras_act: t_ras, pre: t_pre};

    rfsh_timer #(.PER_W(PER_W)) u_timer (
        .clk    (clk),
        .por    (por),
        .en     (rfsh_en),
        .period (period),
        .tick   (tick)
    );

    rfsh_pending #(.CNT_W(CNT_W)) u_pend (
        .clk     (clk),
        .por     (por),
        .ext_rst (ext_rst),
        .tick    (tick),
        .take    (take),
        .pend    (pend_cnt),
        .pend_nz (pend_nz),
        .ovf     (ovf_flag)
    );

    rfsh_seq u_seq (
        .clk     (clk),
        .por     (por),
        .en      (rfsh_en),
        .urgent  (urgent),
        .gnt     (bus_gnt),
        .pend_nz (pend_nz),
        .cfg     (cfg),
        .take    (take),
        .bus_req (bus_req),
        .cas_n   (cas_n),
        .ras_n   (ras_n)
    );
endmodule

// File: tb/tb_rfsh_sched.sv
module tb_rfsh_sched;
    localparam int PER_W = 16;
    localparam int CNT_W = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             por, ext_rst, rfsh_en, urgent, bus_gnt;
    logic [PER_W-1:0] period;
    logic [3:0]       t_cas_ras, t_ras, t_pre;
    logic             bus_req, cas_n, ras_n, ovf_flag;
    logic [CNT_W-1:0] pend_cnt;

    rfsh_sched #(.PER_W(PER_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .por(por), .ext_rst(ext_rst), .rfsh_en(rfsh_en),
        .period(period), .t_cas_ras(t_cas_ras), .t_ras(t_ras), .t_pre(t_pre),
        .urgent(urgent), .bus_gnt(bus_gnt), .bus_req(bus_req),
        .cas_n(cas_n), .ras_n(ras_n), .pend_cnt(pend_cnt), .ovf_flag(ovf_flag)
    );

    int n_chk = 0, n_bad = 0, n_fall = 0;
    int e_cr = 1, e_ras = 1, e_pre = 1;
    bit mon_on = 1'b0;

    function automatic int eff(input int t);
        return (t == 0) ? 1 : t;
    endfunction

    function automatic int exp_pend(input int edges, input int per);
        int n = edges / (per + 1);
        return (n > 7) ? 7 : n;
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Strobe monitor: measures phase lengths in falling-edge samples.
    logic p_cas = 1'b1, p_ras = 1'b1;
    int   cr_c = 0, ras_c = 0, gap_c = 0;
    bit   gap_on = 1'b0, req_drop = 1'b0;
    always @(negedge clk) begin
        if (por) begin
            p_cas = 1'b1; p_ras = 1'b1; gap_on = 1'b0;
        end else begin
            if (!ras_n && cas_n) check_eq("R5 ras low while cas high", 1, 0);
            if (p_ras && !ras_n) begin
                n_fall++;
                if (mon_on) check_eq("R5 cas-to-ras cycles", cr_c, e_cr);
                ras_c = 0;
            end
            if (!p_ras && ras_n) begin
                check_eq("R6 strobes rise together", int'(cas_n), 1);
                if (mon_on) check_eq("R6 ras width", ras_c, e_ras);
                gap_on = 1'b1; gap_c = 0; req_drop = 1'b0;
            end
            if (p_cas && !cas_n) begin
                if (mon_on && gap_on && !req_drop)
                    check_eq("R6 precharge cycles", gap_c, e_pre);
                gap_on = 1'b0; cr_c = 0;
            end
            if (!cas_n && ras_n) cr_c++;
            if (!ras_n) ras_c++;
            if (gap_on && cas_n && ras_n) gap_c++;
            if (!bus_req) req_drop = 1'b1;
            p_cas = cas_n; p_ras = ras_n;
        end
    end

    task automatic set_phases(input int a, input int b, input int c);
        t_cas_ras = a[3:0]; t_ras = b[3:0]; t_pre = c[3:0];
        e_cr = eff(a); e_ras = eff(b); e_pre = eff(c);
    endtask

    // Stack exactly 'target' demands with the bus withheld, then stop the timer.
    task automatic stack_to(input int target, input int per);
        @(negedge clk);
        bus_gnt = 1'b0; period = PER_W'(per); rfsh_en = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (int'(pend_cnt) >= target) break;
        end
        period = '1;
    endtask

    // Grant the bus until the request is released; return the RAS pulses seen.
    task automatic grant_until_release(output int fell);
        int f0 = n_fall;
        @(negedge clk);
        bus_gnt = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!bus_req) break;
        end
        bus_gnt = 1'b0;
        fell = n_fall - f0;
    endtask

    initial begin
        int p, f, n, f0;
        bit req_seen;
        void'($urandom(32'h5eed_0042));
        por = 1'b1; ext_rst = 1'b0; rfsh_en = 1'b0; urgent = 1'b0; bus_gnt = 1'b0;
        period = 16'd20; set_phases(2, 3, 2);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1 cas_n in reset", int'(cas_n), 1);
        check_eq("R1 ras_n in reset", int'(ras_n), 1);
        check_eq("R1 bus_req in reset", int'(bus_req), 0);
        check_eq("R1 pend_cnt in reset", int'(pend_cnt), 0);
        check_eq("R1 ovf_flag in reset", int'(ovf_flag), 0);

        // R2: interval, directed then random periods, each after a power-on reset
        for (int k = 0; k < 5; k++) begin
            p = (k == 0) ? 20 : int'($urandom_range(30, 2));
            @(posedge clk); #1;
            por = 1'b1; period = PER_W'(p); rfsh_en = 1'b1;
            @(posedge clk); #1;
            por = 1'b0;
            repeat (2 * (p + 1) - 1) @(posedge clk);
            @(negedge clk);
            check_eq("R2 count one edge before second demand", int'(pend_cnt),
                     exp_pend(2 * (p + 1) - 1, p));
            @(negedge clk);
            check_eq("R2 count at second demand", int'(pend_cnt),
                     exp_pend(2 * (p + 1), p));
            check_eq("R4 request with stack non-empty", int'(bus_req), 1);
        end

        // R3: saturation and sticky overflow
        repeat (10 * (p + 1)) @(posedge clk);
        @(negedge clk);
        check_eq("R3 saturated count", int'(pend_cnt), 7);
        check_eq("R3 overflow flag", int'(ovf_flag), 1);

        // R11 / R10: ext_rst clears the flag and nothing else
        period = '1;
        @(negedge clk);
        ext_rst = 1'b1;
        @(negedge clk);
        ext_rst = 1'b0;
        check_eq("R11 flag cleared by ext_rst", int'(ovf_flag), 0);
        check_eq("R10 count kept across ext_rst", int'(pend_cnt), 7);
        repeat (5) @(negedge clk);
        check_eq("R11 flag stays clear", int'(ovf_flag), 0);

        // R7 + R10: full drain while ext_rst is held high
        mon_on = 1'b1;
        ext_rst = 1'b1;
        grant_until_release(f);
        ext_rst = 1'b0;
        check_eq("R10 R7 refreshes during ext_rst", f, 7);
        check_eq("R7 stack emptied", int'(pend_cnt), 0);
        check_eq("R7 request released", int'(bus_req), 0);

        // R5/R6 with zero-valued phases acting as one cycle
        set_phases(0, 0, 0);
        stack_to(4, 3);
        grant_until_release(f);
        check_eq("R5 zero phases burst length", f, 4);

        // Random phase lengths and stack depths
        for (int k = 0; k < 6; k++) begin
            set_phases(int'($urandom_range(15, 1)), int'($urandom_range(15, 1)),
                       int'($urandom_range(15, 1)));
            n = int'($urandom_range(7, 1));
            stack_to(n, int'($urandom_range(12, 2)));
            check_eq("R2 stacked depth", int'(pend_cnt), n);
            grant_until_release(f);
            check_eq("R7 random burst length", f, n);
            check_eq("R7 random burst empties", int'(pend_cnt), 0);
        end

        // R9: disable in the middle of a cycle
        set_phases(3, 4, 2);
        stack_to(3, 5);
        f0 = n_fall;
        bus_gnt = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!cas_n) break;
        end
        rfsh_en = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!bus_req) break;
        end
        check_eq("R9 cycle in progress completes", n_fall - f0, 1);
        check_eq("R9 count after interrupted burst", int'(pend_cnt), 2);
        period = 16'd2;
        req_seen = 1'b0;
        f0 = n_fall;
        repeat (100) begin
            @(negedge clk);
            if (bus_req) req_seen = 1'b1;
        end
        check_eq("R9 no cycles while disabled", n_fall - f0, 0);
        check_eq("R9 no request while disabled", int'(req_seen), 0);
        check_eq("R9 count kept while disabled", int'(pend_cnt), 2);

        // R8: urgent limits each grant to a single cycle
        bus_gnt = 1'b0; period = '1; rfsh_en = 1'b1; urgent = 1'b1;
        grant_until_release(f);
        check_eq("R8 one cycle under urgent", f, 1);
        check_eq("R8 count after urgent grant", int'(pend_cnt), 1);
        grant_until_release(f);
        check_eq("R8 next grant still refreshes", f, 1);
        check_eq("R8 count after second grant", int'(pend_cnt), 0);
        urgent = 1'b0;

        // R1: power-on reset in the middle of a burst
        stack_to(7, 2);
        period = 16'd2;
        repeat (10) @(negedge clk);
        check_eq("R3 overflow before reset", int'(ovf_flag), 1);
        bus_gnt = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!ras_n) break;
        end
        por = 1'b1;
        @(negedge clk);
        check_eq("R1 cas_n after por", int'(cas_n), 1);
        check_eq("R1 ras_n after por", int'(ras_n), 1);
        check_eq("R1 pend_cnt after por", int'(pend_cnt), 0);
        check_eq("R1 ovf_flag after por", int'(ovf_flag), 0);
        check_eq("R1 bus_req after por", int'(bus_req), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule